// File: doc/BRIEF.md
# Clocked handshake completion waiter

This block waits for a target device to signal that an operation has finished. The target signals completion by pulling a shared data line high and then releasing it low again. After a one-cycle start request, the block drives a serial clock of its own that begins low and has a fixed half period. It watches the data line until a high level appears, and then until the line returns low. A single counter bounds the whole wait. If the count runs out first, the block gives up and reports a timeout.

A second mode covers the acquire step that follows power-up. In that mode the clock pin is not driven at all, because the target does not need clocks, and only the data line is watched. The mode is captured together with the start request. The raw data line first passes through a two-flop synchronizer. The synchronized level is then checked on every system clock cycle, so a brief high excursion is not missed.

Top module: `ack_handshake_wait`

## Requirements
- R1: After synchronous active-low reset, `busy_o`, `done_o`, `timeout_o`, `sclk_oe_o` and `sclk_o` are all 0.
- R2: A start pulse seen while idle begins a wait, and `busy_o` reads 1 from the next cycle. A start pulse seen while busy is ignored and does not restart the timeout count.
- R3: In clocked mode (`clk_en_i` = 1 at start), `sclk_oe_o` is 1 for the whole wait. `sclk_o` starts low and toggles every `HALF_CYC` system cycles. The default of 16 at a 250 MHz system clock gives 7.8 MHz, below the 8 MHz ceiling.
- R4: The first phase ends when the synchronized data reads 1. In clocked mode this counts only while `sclk_o` is low.
- R5: The second phase ends on the first cycle in which the synchronized data reads 0. `done_o` rises on the third rising edge after the raw line falls.
- R6: A raw high excursion of three system cycles, placed inside a low half of the clock, is enough to complete the first phase.
- R7: One timeout count covers both phases. If no completion occurs, `timeout_o` rises exactly `WAIT_LIMIT` cycles after the start edge, whichever phase is active.
- R8: `done_o` and `timeout_o` are single-cycle pulses and are never high together. If completion and expiry fall in the same cycle, completion wins.
- R9: In acquire mode (`clk_en_i` = 0 at start), `sclk_oe_o` stays 0 for the whole wait. A two-cycle raw high excursion is still detected.
- R10: After `done_o` or `timeout_o`, the block is idle, with `busy_o` and `sclk_oe_o` both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a wait |
| clk_en_i | input | 1 | Mode captured at start: 1 generates clocks, 0 is acquire with no clocks |
| sda_i | input | 1 | Raw level of the shared data line |
| sclk_oe_o | output | 1 | Drive enable for the serial clock pin |
| sclk_o | output | 1 | Serial clock level while driven |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle pulse: high-then-low handshake seen |
| timeout_o | output | 1 | One-cycle pulse: wait limit reached |

## Verification
The bench places a three-cycle high excursion just after the clock falls, and a two-cycle excursion in acquire mode. A design that sampled only once per serial clock period, or only on clock edges, would miss these excursions and time out. It also lets the data line go high and stay there, to show that the limit is shared between the phases. A design that reloaded its counter on the phase change would report the timeout too late. Further checks cover four more faults: a counter restarted by a second start pulse, a done pulse that arrives off by one cycle, a clock pin driven during acquire, and a half period that differs from the parameter.

// File: rtl/ack_wait_pkg.sv
// Package: shared types for the handshake waiter.
// Assumes: nothing beyond IEEE 1800-2017.
package ack_wait_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } wait_st_e;
endpackage

// File: rtl/ack_sync2.sv
// Two-flop synchronizer for a bus of independent single-bit lines.
// Assumes: each bit is a level that stays stable for longer than one cycle.
module ack_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        // Two stages of capture for each bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end
        assign sync_o[b] = stab_q;
    end
endmodule

// File: rtl/ack_sclk_gen.sv
// Serial clock generator. While run_i is high it produces a square wave
// that starts low, with each level lasting HALF_CYC system cycles.
// While run_i is low the output is held low and the phase restarts.
// Assumes: HALF_CYC >= 1.
module ack_sclk_gen #(
    parameter int HALF_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HW-1:0] HLAST = HW'(HALF_CYC - 1);

    logic [HW-1:0] half_q;
    logic          lvl_q;

    // Count within a half period and toggle the level at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            half_q <= '0;
            lvl_q  <= 1'b0;
        end else if (half_q == HLAST) begin
            half_q <= '0;
            lvl_q  <= ~lvl_q;
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    assign sclk_o = lvl_q;
endmodule

// File: rtl/ack_timer.sv
// Wait-limit counter. clear_i restarts it. It counts while run_i is high
// and saturates on its last value, where expire_o is high.
// Assumes: WAIT_LIMIT >= 2.
module ack_timer #(
    parameter int WAIT_LIMIT = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(WAIT_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count elapsed busy cycles, holding on the final value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ack_handshake_wait.sv
// Top level of the handshake waiter. A start request arms a two-phase wait:
// first the synchronized data line must read high, then low. In clocked mode
// the block drives its own serial clock, and phase one accepts high only
// while that clock is low. In acquire mode no clock is driven. One counter
// bounds both phases. done_o or timeout_o pulses for one cycle at the end.
// Assumes: sda_i is asynchronous; start_i is synchronous to clk.
module ack_handshake_wait
    import ack_wait_pkg::*;
#(
    parameter int HALF_CYC   = 16,
    parameter int WAIT_LIMIT = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clk_en_i,
    input  logic sda_i,
    output logic sclk_oe_o,
    output logic sclk_o,
    output logic busy_o,
    output logic done_o,
    output logic timeout_o
);
    wait_st_e state_q;
    wait_st_e state_d;
    logic     mode_q;
    logic     sda_s;
    logic     sclk_int;
    logic     expire;
    logic     take;
    logic     run_clk;
    logic     rise_ok;
    logic     fall_ok;
    logic     done_q;
    logic     to_q;

    ack_sync2 #(.WIDTH(1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sda_i),
        .sync_o  (sda_s)
    );

    ack_sclk_gen #(.HALF_CYC(HALF_CYC)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_clk),
        .sclk_o (sclk_int)
    );

    ack_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (take),
        .run_i    (busy_o),
        .expire_o (expire)
    );

    // Decode acceptance, phase completion and clock run conditions.
    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        take    = start_i && !busy_o;
        run_clk = busy_o && mode_q;
        rise_ok = (state_q == ST_RISE) && sda_s && (!mode_q || !sclk_int);
        fall_ok = (state_q == ST_FALL) && !sda_s;
    end

    // Next-state choice: completion has priority over expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_RISE;
            ST_RISE: begin
                if (rise_ok)     state_d = ST_FALL;
                else if (expire) state_d = ST_IDLE;
            end
            ST_FALL: begin
                if (fall_ok || expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured mode and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) mode_q <= clk_en_i;
            done_q  <= fall_ok;
            to_q    <= expire && !rise_ok && !fall_ok;
        end
    end

    assign sclk_oe_o = run_clk;
    assign sclk_o    = sclk_int;
    assign done_o    = done_q;
    assign timeout_o = to_q;
endmodule

// File: rtl/ack_handshake_wait_chk.sv
// Checker for ack_handshake_wait, bound to every instance.
// Assumes: the same parameters as the checked instance.
module ack_handshake_wait_chk #(
    parameter int HALF_CYC   = 16,
    parameter int WAIT_LIMIT = 25_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic sclk_oe_o,
    input logic sclk_o,
    input logic busy_o,
    input logic done_o,
    input logic timeout_o
);
    localparam int BW = $clog2(WAIT_LIMIT + 2) + 1;
    localparam int LW = $clog2(HALF_CYC + 2) + 1;

    logic [BW-1:0] busy_cnt;
    logic [LW-1:0] lvl_cnt;
    logic          sclk_q;

    // Count the busy cycles of the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) busy_cnt <= '0;
        else if (busy_cnt != {BW{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
    end

    // Measure how long the driven clock has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk_oe_o) begin
            lvl_cnt <= '0;
            sclk_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_o;
            if (sclk_o != sclk_q) lvl_cnt <= LW'(1);
            else if (lvl_cnt != {LW{1'b1}}) lvl_cnt <= lvl_cnt + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_oe_o);

    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe_o && sclk_o != sclk_q) |-> (lvl_cnt >= LW'(HALF_CYC)));

    a_r7_no_early_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (busy_cnt >= BW'(WAIT_LIMIT)));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r10_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |-> !busy_o);
endmodule

bind ack_handshake_wait ack_handshake_wait_chk #(
    .HALF_CYC   (HALF_CYC),
    .WAIT_LIMIT (WAIT_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sclk_oe_o (sclk_oe_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
);

// File: tb/ack_handshake_wait_tb_top.sv
// Directed bench for ack_handshake_wait: one task per scenario.
module ack_handshake_wait_tb_top;
    localparam int TB_HALF  = 16;
    localparam int TB_LIMIT = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic clk_en_i = 1'b1;
    logic sda_i = 1'b0;
    logic sclk_oe_o, sclk_o, busy_o, done_o, timeout_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    ack_handshake_wait #(.HALF_CYC(TB_HALF), .WAIT_LIMIT(TB_LIMIT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .clk_en_i  (clk_en_i),
        .sda_i     (sda_i),
        .sclk_oe_o (sclk_oe_o),
        .sclk_o    (sclk_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .timeout_o (timeout_o)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_start(input bit mode);
        @(negedge clk);
        clk_en_i = mode;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk(busy_o == 0 && done_o == 0 && timeout_o == 0, "R1 status", busy_o, 0);
        chk(sclk_oe_o == 0 && sclk_o == 0, "R1 clock pins", sclk_oe_o, 0);
        rst_n = 1'b1;
        step();
    endtask

    // R7, R3, R2: clocked wait with no reply; second start ignored.
    task automatic t_timeout_rise();
        int n = 0;
        int last_t = -1;
        int bad_half = 0;
        bit prev;
        bit seen_done = 0;
        sda_i = 1'b0;
        pulse_start(1'b1);
        #1;
        prev = sclk_o;
        chk(sclk_o == 0, "R3 starts low", sclk_o, 0);
        while (n < TB_LIMIT + 20) begin
            step();
            n++;
            if (n == 1000) start_i = 1'b1;
            if (n == 1001) start_i = 1'b0;
            if (n == 500) begin
                chk(busy_o == 1, "R2 busy", busy_o, 1);
                chk(sclk_oe_o == 1, "R3 clock driven", sclk_oe_o, 1);
            end
            if (sclk_oe_o && sclk_o != prev) begin
                if (last_t >= 0 && n - last_t != TB_HALF) bad_half = n - last_t;
                last_t = n;
            end
            prev = sclk_o;
            if (done_o) seen_done = 1;
            if (timeout_o) break;
        end
        chk(bad_half == 0, "R3 half period", bad_half, TB_HALF);
        chk(n == TB_LIMIT, "R7 R2 timeout cycle", n, TB_LIMIT);
        chk(!seen_done, "R8 no done", seen_done, 0);
        step();
        chk(timeout_o == 0, "R8 timeout single", timeout_o, 0);
        chk(busy_o == 0 && sclk_oe_o == 0, "R10 idle after timeout", busy_o, 0);
    endtask

    // R7: limit is shared when the line rises and then stays high.
    task automatic t_timeout_fall();
        int n = 0;
        sda_i = 1'b0;
        pulse_start(1'b1);
        while (n < TB_LIMIT + 20) begin
            step();
            n++;
            if (n == 100) sda_i = 1'b1;
            if (timeout_o) break;
        end
        chk(n == TB_LIMIT, "R7 shared limit", n, TB_LIMIT);
        sda_i = 1'b0;
        repeat (4) step();
    endtask

    // R4, R5, R8, R10: full clocked handshake with exact done latency.
    task automatic t_handshake();
        int m = 0;
        bit d2;
        sda_i = 1'b1;
        pulse_start(1'b1);
        #1;
        chk(busy_o == 1, "R2 busy after start", busy_o, 1);
        repeat (60) step();
        chk(busy_o == 1 && done_o == 0, "R4 still waiting for low", busy_o, 1);
        sda_i = 1'b0;
        step(); step();
        d2 = done_o;
        step();
        m = 3;
        chk(d2 == 0, "R5 not early", d2, 0);
        chk(done_o == 1, "R5 done latency", done_o, 1);
        chk(timeout_o == 0, "R8 no timeout with done", timeout_o, 0);
        step();
        chk(done_o == 0, "R8 done single", done_o, 0);
        chk(busy_o == 0 && sclk_oe_o == 0, "R10 idle after done", busy_o, m - 3);
    endtask

    // R6: three-cycle excursion inside a low half completes phase one.
    task automatic t_short_pulse();
        bit prev = 1'b0;
        bit got = 0;
        bit bad = 0;
        sda_i = 1'b0;
        pulse_start(1'b1);
        for (int i = 0; i < 200; i++) begin
            step();
            if (prev && !sclk_o) break;
            prev = sclk_o;
        end
        sda_i = 1'b1;
        repeat (3) step();
        sda_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (timeout_o) bad = 1;
            if (done_o) begin got = 1; break; end
        end
        chk(got, "R6 short excursion", got, 1);
        chk(!bad, "R6 no timeout", bad, 0);
        repeat (2) step();
    endtask

    // R9: acquire mode never drives the clock and sees a two-cycle excursion.
    task automatic t_acquire();
        bit oe_seen = 0;
        bit got = 0;
        sda_i = 1'b0;
        pulse_start(1'b0);
        for (int i = 0; i < 50; i++) begin
            step();
            if (sclk_oe_o) oe_seen = 1;
        end
        chk(busy_o == 1, "R9 waiting", busy_o, 1);
        sda_i = 1'b1;
        repeat (2) step();
        sda_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (sclk_oe_o) oe_seen = 1;
            if (done_o) begin got = 1; break; end
        end
        chk(!oe_seen, "R9 clock not driven", oe_seen, 0);
        chk(got, "R9 short excursion detected", got, 1);
    endtask

    initial begin
        t_reset();
        t_timeout_rise();
        t_timeout_fall();
        t_handshake();
        t_short_pulse();
        t_acquire();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule